// File: doc/BRIEF.md
# Address Bit 20 Gate

This block sits on the physical address path and decides whether address bit 20 (the 21st bit, counting from zero) reaches memory. When the gate is closed, bit 20 is held at zero, so any access between 1 MiB and 2 MiB lands on the matching location in the first megabyte. This recreates the old wraparound. Every other address bit always passes through unchanged.

The gate opens when any one of four independent sources is active:
- bit 1 of a system control byte at I/O port 0x92;
- a gate bit from the keyboard controller's output port, which arrives as an input;
- a side-effect port at I/O 0xEE, which a read sets and a write clears;
- an active-low mask pin, whose high level counts as an enable.

The block also decodes the fast-reset controls that share these ports, and raises a one-cycle reset request for them.

Top module: `a20_gate`

## Requirements
- R1: `addr_out` equals `addr_in` in every bit except bit 20. Bit 20 of `addr_out` is zero whenever the gate is closed, and equals `addr_in[20]` when it is open.
- R2: After reset, the stored sources are inactive. With `kbc_gate` low and `mask_n` low, the gate is closed, a read of 0x92 returns 0x00, and `rst_req` is low.
- R3: A write to 0x92 with data bit 1 set opens the gate from the next cycle. A write with data bit 1 clear removes that source.
- R4: While `io_rd` addresses 0x92, `io_rdata` returns the whole stored byte in the same cycle. Bits 7..2 are plain storage. Reads of any other port return 0x00.
- R5: A write to 0x92 that takes stored bit 0 from 0 to 1 raises `rst_req` for exactly the next cycle. Writing bit 0 as 1 when it is already 1 raises nothing.
- R6: Any write to 0xEF raises `rst_req` for the next cycle, whatever the data.
- R7: Any read of 0xEE turns that source on, and any write to 0xEE turns it off. The data value is ignored. If a read and a write to 0xEE coincide, the write wins.
- R8: While `kbc_gate` is high, the gate is open in the same cycle.
- R9: While `mask_n` is high, the gate is open. Driving it low removes only its own contribution.
- R10: The gate is the OR of all four sources. It closes only when every source is inactive.
- R11: Reads and writes to any other port leave all sources, the stored byte and `rst_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | I/O read strobe, one access per cycle |
| io_wr | input | 1 | I/O write strobe, one access per cycle |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| kbc_gate | input | 1 | Gate bit from the keyboard controller output port |
| mask_n | input | 1 | Active-low mask; high counts as an enable source |
| addr_in | input | AW | Physical address from the core |
| addr_out | output | AW | Gated physical address to memory |
| gate_on | output | 1 | Current gate state |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach from the ports is one where the gate is open from exactly one source while the others are quiet. Only then does clearing that source visibly close the gate, and only then does a read-set on 0xEE followed by a write-clear show any effect. Reset pulses must also be told apart from repeated writes of bit 0 as one.

The stimulus first walks each source on and off alone, with the keyboard bit and the mask held inactive. It then mixes random accesses to the three decoded ports and to neighbouring ports with random toggling of the two pins. A behavioural model is compared against the design on every clock.

// File: rtl/a20_gate.sv
module a20_gate #(
  parameter int AW    = 32,
  parameter int GBIT  = 20,
  parameter logic [15:0] P_SYS  = 16'h0092,
  parameter logic [15:0] P_GATE = 16'h00EE,
  parameter logic [15:0] P_RST  = 16'h00EF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          kbc_gate,
  input  logic          mask_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          gate_on,
  output logic          rst_req
);
  localparam logic [AW-1:0] GMASK = AW'(1) << GBIT;

  logic [7:0] sys_q;
  logic       side_q;

  wire hit_sys  = io_addr == P_SYS;
  wire hit_gate = io_addr == P_GATE;
  wire hit_rst  = io_addr == P_RST;
  wire wr_sys   = io_wr && hit_sys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q   <= 8'h00;
      side_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_sys) sys_q <= io_wdata;
      if (io_wr && hit_gate) side_q <= 1'b0;
      else if (io_rd && hit_gate) side_q <= 1'b1;
      rst_req <= (wr_sys && io_wdata[0] && !sys_q[0]) || (io_wr && hit_rst);
    end
  end

  assign io_rdata = (io_rd && hit_sys) ? sys_q : 8'h00;
  assign gate_on  = sys_q[1] | side_q | kbc_gate | mask_n;
  assign addr_out = gate_on ? addr_in : (addr_in & ~GMASK);
endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk #(
  parameter int AW = 32,
  parameter int GBIT = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   io_addr,
  input logic          io_rd,
  input logic          io_wr,
  input logic [7:0]    io_wdata,
  input logic          kbc_gate,
  input logic          mask_n,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          gate_on,
  input logic          rst_req
);
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n) addr_out[GBIT-1:0] == addr_in[GBIT-1:0]); // R1
  AST_SYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && io_addr == 16'h0092 && io_wdata[1]) |=> gate_on); // R3
  AST_EF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && io_addr == 16'h00EF) |=> rst_req); // R6
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> $past(io_wr)); // R5
  AST_SIDE_SET: assert property (@(posedge clk) disable iff (!rst_n) (io_rd && !io_wr && io_addr == 16'h00EE) |=> gate_on); // R7
  AST_KBC_OPEN: assert property (@(posedge clk) disable iff (!rst_n) kbc_gate |-> gate_on); // R8
  AST_MASK_OPEN: assert property (@(posedge clk) disable iff (!rst_n) mask_n |-> gate_on); // R9
endmodule

bind a20_gate a20_gate_chk #(.AW(AW), .GBIT(GBIT)) u_chk (.*);

// File: tb/a20_gate_test.sv
module a20_gate_test;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic kbc_gate = 0, mask_n = 0;
  logic [AW-1:0] addr_in = 0, addr_out;
  logic gate_on, rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  a20_gate uut (.*);

  always #2 clk = ~clk;

  // behavioural reference
  int m_sys = 0, m_side = 0, m_req = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sys = 0; m_side = 0; m_req = 0;
    end else begin
      int nreq;
      nreq = 0;
      if (io_wr && io_addr == 16'h0092 && io_wdata[0] && (m_sys % 2) == 0) nreq = 1;
      if (io_wr && io_addr == 16'h00EF) nreq = 1;
      if (io_wr && io_addr == 16'h0092) m_sys = io_wdata;
      if (io_wr && io_addr == 16'h00EE) m_side = 0;
      else if (io_rd && io_addr == 16'h00EE) m_side = 1;
      m_req = nreq;
    end
    #1;
    begin
      int g;
      logic [AW-1:0] ea;
      g = ((m_sys / 2) % 2 == 1 || m_side == 1 || kbc_gate || mask_n) ? 1 : 0;
      ea = addr_in;
      if (g == 0) ea[20] = 1'b0;
      chk("R10 gate", gate_on, g);
      chk("R1 addr_out", addr_out, ea);
      chk("R5/R6 rst_req", rst_req, m_req);
      chk("R4 io_rdata", io_rdata, (io_rd && io_addr == 16'h0092) ? m_sys[7:0] : 8'h00);
    end
  end

  task automatic acc(logic [15:0] a, logic rd, logic wr, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    addr_in = $urandom;
    @(negedge clk);
    io_rd = 0; io_wr = 0;
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    addr_in = 32'h0012_3456;
    repeat (3) @(negedge clk);
    chk("R2 gate after reset", gate_on, 0);
    chk("R2 addr wraps", addr_out, 32'h0002_3456);
    rst_n = 1;
    acc(16'h0092, 1, 0, 0);
    // R3 open and close via 0x92 bit 1
    acc(16'h0092, 0, 1, 8'hA2);
    chk("R3 open", gate_on, 1);
    acc(16'h0092, 0, 1, 8'hA0);
    chk("R3 close", gate_on, 0);
    // R5 rising bit 0 and repeated 1
    acc(16'h0092, 0, 1, 8'h01);
    acc(16'h0092, 0, 1, 8'h01);
    acc(16'h0092, 0, 1, 8'h00);
    // R6 and R11
    acc(16'h00EF, 0, 1, 8'h00);
    acc(16'h0093, 0, 1, 8'hFF);
    acc(16'h0060, 1, 0, 8'h00);
    chk("R11 other port", gate_on, 0);
    // R7 side port, including read+write together
    acc(16'h00EE, 1, 0, 8'h00);
    chk("R7 set", gate_on, 1);
    acc(16'h00EE, 0, 1, 8'hFF);
    chk("R7 clear", gate_on, 0);
    acc(16'h00EE, 1, 1, 8'h00);
    chk("R7 write wins", gate_on, 0);
    // R8 / R9 pins
    @(negedge clk); kbc_gate = 1; #1 chk("R8 kbc", gate_on, 1);
    @(negedge clk); kbc_gate = 0; mask_n = 1; #1 chk("R9 mask high", gate_on, 1);
    @(negedge clk); mask_n = 0; #1 chk("R9 mask low", gate_on, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      case ($urandom % 5)
        0: a = 16'h0092; 1: a = 16'h00EE; 2: a = 16'h00EF;
        3: a = 16'h0093; default: a = 16'h00ED;
      endcase
      if ($urandom % 8 == 0) kbc_gate = $urandom;
      if ($urandom % 8 == 0) mask_n = $urandom;
      acc(a, 1'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule